// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a parameterised set of message-signalled interrupt vectors. Each one holds a 64-bit target address, a 32-bit payload and a mask bit. The block also keeps a pending bit per vector and a function-level control with an enable bit and a mask-all bit. Device logic raises requests by vector index. When the vector is deliverable, the block presents a memory-write message (address plus data) on a valid/ready output. When the vector is masked, the block only remembers the request as pending and sends it once the vector becomes unmasked.

Software uses a 32-bit register port that takes aligned accesses only. It covers three regions. The vector table starts at byte 0. The read-only pending array starts at `PBA_BASE`. The control word sits at `CTRL_ADDR`. Device logic gives a per-vector in-use flag. A vector whose flag is clear ignores requests and holds no pending state.

Top module: `msix_vector_table`

## Requirements
- R1: After reset, every table word reads zero except each vector's control word, which reads 1 (masked). The pending array reads zero. The enable and mask-all bits read zero.
- R2: Each table entry spans 16 bytes at byte offset 16*v. Offset +0 holds address bits 31:0, +4 holds address bits 63:32, +8 holds the data word and +12 holds the control word. The control word keeps only the mask in bit 0, and its other bits read 0.
- R3: A vector counts as masked when its own mask bit is 1, when enable is 0, or when mask-all is 1. A request on a masked vector sends no message and sets that vector's pending bit.
- R4: A request on an unmasked, in-use vector produces a message carrying that vector's {address high, address low} and data. msg_valid rises on the second rising edge after the request cycle.
- R5: When a vector with its pending bit set becomes unmasked, its pending bit clears and its message is sent. The unmasking can come from its own mask bit, from setting enable, or from clearing mask-all.
- R6: The pending array is read at PBA_BASE+4k. Bit j of word k belongs to vector 32k+j. The array is sized for the vector count rounded up to 64, and bits beyond the vector count read 0. Writes to the array are ignored.
- R7: Requests with an index of NUM_VEC or above are ignored. Requests on a vector whose vec_used bit is 0 are also ignored. Clearing vec_used for a vector clears its pending bit.
- R8: When several vectors are deliverable, messages go out one per handshake, lowest index first. msg_valid, msg_addr and msg_data stay stable while msg_valid is high and msg_ready is low.
- R9: A write to a vector's address or data words does not change a message already presented on the output. It affects only later messages.
- R10: An access with reg_addr[1:0] not equal to 0 changes nothing, and its read returns zero.
- R11: The control word at CTRL_ADDR holds enable in bit 15 and mask-all in bit 14, both writable. Bits 10:0 read NUM_VEC-1 and are read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| vec_used | input | NUM_VEC | Per-vector in-use flags from device logic |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | VW | Requested vector index |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by downstream |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The first requests go to a single vector, and the second half arrives with the vector unmasked. This separates the immediate-send path from the pending path. Later requests arrive while the function is masked, first through mask-all and then by clearing enable. Releasing the function mask must then drain all the pending vectors in index order, which tells the per-vector and function-level unmask paths apart. The drain runs with msg_ready held low for a while, which exercises the hold rule. Further patterns send requests that must vanish: an index out of range, a vector not in use, and a pending bit wiped by clearing its in-use flag. A write to a vector's data while its message is parked shows whether the output captured its values or follows the table.

// File: rtl/msix_vector_table.sv
module msix_vector_table #(
  parameter int NUM_VEC = 8,
  parameter int AW = 12,
  parameter logic [AW-1:0] PBA_BASE = 12'h800,
  parameter logic [AW-1:0] CTRL_ADDR = 12'hC00,
  localparam int VW = $clog2(NUM_VEC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_VEC-1:0] vec_used,
  input  logic              req_valid,
  input  logic [VW-1:0]     req_vec,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int IW = $clog2(NUM_VEC);
  localparam int PBA_WORDS = ((NUM_VEC + 63) / 64) * 2;
  localparam int PW = PBA_WORDS * 32;
  localparam int PIW = $clog2(PBA_WORDS);
  localparam logic [AW-1:0] TBL_END = AW'(NUM_VEC * 16);
  localparam logic [AW-1:0] PBA_END = PBA_BASE + AW'(PBA_WORDS * 4);

  logic [31:0] a_lo [NUM_VEC];
  logic [31:0] a_hi [NUM_VEC];
  logic [31:0] dat  [NUM_VEC];
  logic [NUM_VEC-1:0] vmask, pend, dlv, set_v, clr_v;
  logic fn_en, fn_all;

  wire aligned = reg_addr[1:0] == 2'b00;
  wire tbl_hit = aligned && reg_addr < TBL_END;
  wire pba_hit = aligned && reg_addr >= PBA_BASE && reg_addr < PBA_END;
  wire ctl_hit = aligned && reg_addr == CTRL_ADDR;
  wire [IW-1:0] ent = reg_addr[IW+3:4];
  wire [1:0] word = reg_addr[3:2];
  wire fn_masked = !fn_en || fn_all;
  wire [PW-1:0] pend_ext = PW'(pend);

  assign dlv = pend & ~vmask & vec_used & {NUM_VEC{!fn_masked}};

  logic [IW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (dlv[i]) pick = IW'(i);
  end

  wire load = (|dlv) && (!msg_valid || msg_ready);
  wire req_hit = req_valid && req_vec < VW'(NUM_VEC) && vec_used[req_vec[IW-1:0]];

  assign set_v = req_hit ? (NUM_VEC'(1) << req_vec[IW-1:0]) : '0;
  assign clr_v = load ? (NUM_VEC'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        a_lo[i] <= '0;
        a_hi[i] <= '0;
        dat[i]  <= '0;
      end
      vmask     <= '1;
      pend      <= '0;
      fn_en     <= 1'b0;
      fn_all    <= 1'b0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      if (reg_wr && tbl_hit) begin
        case (word)
          2'd0: a_lo[ent] <= reg_wdata;
          2'd1: a_hi[ent] <= reg_wdata;
          2'd2: dat[ent]  <= reg_wdata;
          default: vmask[ent] <= reg_wdata[0];
        endcase
      end
      if (reg_wr && ctl_hit) begin
        fn_en  <= reg_wdata[15];
        fn_all <= reg_wdata[14];
      end
      pend <= ((pend & ~clr_v) | set_v) & vec_used;
      if (load) begin
        msg_valid <= 1'b1;
        msg_addr  <= {a_hi[pick], a_lo[pick]};
        msg_data  <= dat[pick];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit) begin
      case (word)
        2'd0: reg_rdata = a_lo[ent];
        2'd1: reg_rdata = a_hi[ent];
        2'd2: reg_rdata = dat[ent];
        default: reg_rdata = {31'b0, vmask[ent]};
      endcase
    end else if (pba_hit) begin
      reg_rdata = pend_ext[reg_addr[PIW+1:2]*32 +: 32];
    end else if (ctl_hit) begin
      reg_rdata = {16'b0, fn_en, fn_all, 3'b0, 11'(NUM_VEC - 1)};
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  assert_drop_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_valid) |-> $past(msg_ready));

  assert_unused_no_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & ~$past(vec_used)) == '0);

  assert_fn_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(fn_en && !fn_all));

  assert_masked_req_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit && fn_masked && vec_used == '1 |=> pend != '0);
endmodule

// File: tb/msix_vector_table_tb.sv
module msix_vector_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [11:0] PBA = 12'h800;
  localparam logic [11:0] CTL = 12'hC00;

  logic clk = 0, rst_n = 0, reg_wr = 0, req_valid = 0, msg_ready = 1, msg_valid;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, msg_data;
  logic [NV-1:0] vec_used = '1;
  logic [3:0] req_vec = 0;
  logic [63:0] msg_addr;

  int checks = 0, errors = 0;
  logic [95:0] expq [$];
  logic [31:0] e_lo [NV], e_hi [NV], e_dat [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_vector_table u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_used(vec_used),
    .req_valid(req_valid), .req_vec(req_vec), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_msg(input int v);
    expq.push_back({e_hi[v], e_lo[v], e_dat[v]});
  endtask

  // monitor: pops expected messages at each handshake
  logic p_v = 0, p_r = 0;
  logic [95:0] p_m = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_v && !p_r) check("R8 hold", {msg_valid, msg_addr, msg_data}, {1'b1, p_m});
      if (msg_valid && msg_ready) begin
        if (expq.size() == 0) check("R3 unexpected message", {msg_addr, msg_data}, 96'h0);
        else check("R4 message content", {msg_addr, msg_data}, expq.pop_front());
      end
      p_v = msg_valid; p_r = msg_ready; p_m = {msg_addr, msg_data};
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    check(tag, {64'b0, reg_rdata}, {64'b0, exp});
  endtask

  task automatic req(input logic [3:0] v);
    @(posedge clk); #1;
    req_valid = 1; req_vec = v;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 / R11 reset state
    rd(CTL, 32'h0000_0007, "R1 R11 control after reset");
    rd(12'h03C, 32'h1, "R1 mask set after reset");
    rd(12'h030, 32'h0, "R1 addr low zero");
    rd(PBA, 32'h0, "R1 pending zero");
    // R2 program table
    for (int v = 0; v < NV; v++) begin
      e_lo[v] = 32'h1000 + v * 16; e_hi[v] = 32'hA0 + v; e_dat[v] = 32'hD000 + v;
      wr(12'(v*16), e_lo[v]); wr(12'(v*16+4), e_hi[v]); wr(12'(v*16+8), e_dat[v]);
    end
    rd(12'h054, 32'hA5, "R2 addr high entry 5");
    rd(12'h058, 32'hD005, "R2 data entry 5");
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h02C, 32'h1, "R2 control keeps only mask bit");
    // R11 enable
    wr(CTL, 32'h0000_FFFF);
    rd(CTL, 32'h0000_C007, "R11 enable+maskall writable, size read-only");
    wr(CTL, 32'h0000_8000);
    // R3 per-vector mask
    req(2); idle(4);
    rd(PBA, 32'h4, "R3 masked request pends");
    expect_msg(2);
    wr(12'h02C, 32'h0); idle(4);
    rd(PBA, 32'h0, "R5 pending cleared on unmask");
    for (int v = 0; v < NV; v++) if (v != 2) wr(12'(v*16+12), 32'h0);
    idle(3);
    // R4 direct delivery
    expect_msg(6); req(6); idle(4);
    // R3 mask-all then R5/R8 drain in order with stall
    wr(CTL, 32'h0000_C000);
    req(5); req(1); req(3); idle(2);
    rd(PBA, 32'h2A, "R3 R6 pending layout under mask-all");
    msg_ready = 0;
    expect_msg(1); expect_msg(3); expect_msg(5);
    wr(CTL, 32'h0000_8000); idle(5);
    check("R8 valid held while stalled", {95'b0, msg_valid}, 96'h1);
    msg_ready = 1; idle(8);
    check("R8 drain complete", 96'(expq.size()), 96'h0);
    // R7 ignored requests
    req(4'd8); req(4'd15);
    vec_used[4] = 0; req(4); idle(4);
    rd(PBA, 32'h0, "R7 out-of-range and unused ignored");
    vec_used[4] = 1;
    wr(CTL, 32'h0000_C000); req(7); idle(2);
    rd(PBA, 32'h80, "R7 pending before unuse");
    vec_used[7] = 0; idle(2);
    rd(PBA, 32'h0, "R7 unuse clears pending");
    vec_used[7] = 1;
    wr(CTL, 32'h0000_8000); idle(5);
    // R9 parked message keeps captured values
    msg_ready = 0;
    expect_msg(0); req(0); idle(3);
    e_dat[0] = 32'hBEEF_0000;
    wr(12'h008, e_dat[0]); idle(2);
    msg_ready = 1; idle(2);
    expect_msg(0); req(0); idle(4);
    // R10 misaligned access
    wr(12'h019, 32'h1234_5678);
    rd(12'h018, e_dat[1], "R10 misaligned write ignored");
    rd(12'h01A, 32'h0, "R10 misaligned read is zero");
    // R6 pending read-only and padded
    wr(PBA, 32'hFFFF_FFFF);
    rd(PBA, 32'h0, "R6 pending not writable");
    rd(PBA + 12'h4, 32'h0, "R6 padded pending word reads zero");
    // R3/R5 enable bit as function mask
    wr(CTL, 32'h0); req(3); idle(2);
    rd(PBA, 32'h8, "R3 disabled function pends");
    expect_msg(3);
    wr(CTL, 32'h0000_8000); idle(6);
    check("R5 all expected messages seen", 96'(expq.size()), 96'h0);
    finish_run();
  end
endmodule